// File: doc/BRIEF.md
# Tree-Structured Leading-Zero Counter

This block is a purely combinational unit that reports how many zero bits lie above the highest set bit of an operand. It serves as the count-leading-zeros operation of a single-cycle processor's ALU. The result appears in the same cycle as the operand, with no clock and no internal state.

The count is formed by a balanced tree. Each leaf looks at one 4-bit slice and returns a 2-bit partial count together with a flag that says the slice is empty. Each level above a leaf joins two neighbouring results into one that covers twice the width. The upper neighbour's empty flag picks which of the two partial counts is passed on. It also becomes the new most significant count bit. The path from operand to result therefore passes through log2(width) - 2 two-way multiplexers after the leaves.

The operand width is a parameter and may be any power of two from 4 to 128. The count output is one bit wider than log2(width), so that an all-zero operand can report the full width.

Top module: `lzc_unit`

## Requirements
- R1: The leading 4-bit slice of a non-zero operand sets the count as follows, whatever the lower bits hold: a slice of 1xxx gives 0, 01xx gives 1, 001x gives 2 and 0001 gives 3.
- R2: For every non-zero operand, `lz_count_o` equals the number of consecutive zero bits counted downward from bit WIDTH-1 before the first set bit. The bit at position WIDTH-1-count is set, and every bit above it is clear.
- R3: An all-zero operand gives `lz_count_o` equal to WIDTH (32, binary 100000, at the default width).
- R4: `all_zero_o` is 1 exactly when every operand bit is 0, and 0 otherwise.
- R5: An operand with only bit k set gives a count of WIDTH-1-k, for every k from 0 to WIDTH-1.
- R6: An operand with its most significant bit set gives a count of 0. This includes the all-ones operand.
- R7: `lz_count_o` never exceeds WIDTH.
- R8: Bits below the highest set bit have no effect on the outputs. Changing any of them leaves `lz_count_o` and `all_zero_o` unchanged.
- R9: The same structure gives correct counts at another power-of-two width. At WIDTH = 64 the all-zero result is 64 and single-bit operands give 63-k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | WIDTH | Value whose leading zeros are counted |
| lz_count_o | output | $clog2(WIDTH)+1 | Number of leading zero bits, 0 to WIDTH |
| all_zero_o | output | 1 | High when the operand has no set bit |

## Verification
The checker assumes the operand carries only 0s and 1s. It evaluates its properties only after the operand has settled to a known value, so the undriven value before the first stimulus is never judged. The bench drives the operand away from the clock edge and samples one time unit later. Every applied value is fully defined, and it is built from shifts, masks and random words, so no X or Z reaches the unit. Random operands are shifted right by a random amount, so that every count from 0 to 32 occurs, and not just the short counts that uniform random words would give.

// File: rtl/lzc_pkg.sv
package lzc_pkg;
  localparam int unsigned LEAF_BITS = 4;
  localparam int unsigned LEAF_CNT_W = 2;

  function automatic int unsigned count_width(input int unsigned w);
    return $clog2(w) + 1;
  endfunction
endpackage

// File: rtl/lzc_leaf4.sv
module lzc_leaf4
  import lzc_pkg::*;
(
  input  logic [LEAF_BITS-1:0]  nibble_i,
  output logic [LEAF_CNT_W-1:0] cnt_o,
  output logic                  zero_o
);
  always_comb begin
    cnt_o[1] = ~(nibble_i[3] | nibble_i[2]);
    cnt_o[0] = ~nibble_i[3] & (nibble_i[2] | ~nibble_i[1]);
    zero_o   = ~(|nibble_i);
  end
endmodule

// File: rtl/lzc_merge.sv
module lzc_merge #(
  parameter int unsigned HALF_CW = 2
) (
  input  logic [HALF_CW-1:0] hi_cnt_i,
  input  logic               hi_zero_i,
  input  logic [HALF_CW-1:0] lo_cnt_i,
  input  logic               lo_zero_i,
  output logic [HALF_CW:0]   cnt_o,
  output logic               zero_o
);
  always_comb begin
    cnt_o[HALF_CW]     = hi_zero_i;
    cnt_o[HALF_CW-1:0] = hi_zero_i ? lo_cnt_i : hi_cnt_i;
    zero_o             = hi_zero_i & lo_zero_i;
  end
endmodule

// File: rtl/lzc_unit.sv
module lzc_unit
  import lzc_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]              operand_i,
  output logic [count_width(WIDTH)-1:0] lz_count_o,
  output logic                          all_zero_o
);
  localparam int unsigned LOG_W  = $clog2(WIDTH);
  localparam int unsigned CNT_W  = LOG_W + 1;
  localparam int unsigned LEAVES = WIDTH / LEAF_BITS;
  localparam int unsigned LEVELS = LOG_W - 2;

  logic [LOG_W-1:0] root_cnt;
  logic             root_zero;

  for (genvar l = 0; l <= LEVELS; l++) begin : gen_lvl
    localparam int unsigned NODES = LEAVES >> l;
    localparam int unsigned CW    = LEAF_CNT_W + l;
    logic [CW-1:0] cnt  [NODES];
    logic          zero [NODES];

    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < NODES; j++) begin : g_node
        lzc_leaf4 u_leaf (
          .nibble_i (operand_i[LEAF_BITS*j +: LEAF_BITS]),
          .cnt_o    (cnt[j]),
          .zero_o   (zero[j])
        );
      end
    end else begin : g_join
      for (genvar j = 0; j < NODES; j++) begin : g_node
        lzc_merge #(.HALF_CW(CW-1)) u_join (
          .hi_cnt_i  (gen_lvl[l-1].cnt[2*j+1]),
          .hi_zero_i (gen_lvl[l-1].zero[2*j+1]),
          .lo_cnt_i  (gen_lvl[l-1].cnt[2*j]),
          .lo_zero_i (gen_lvl[l-1].zero[2*j]),
          .cnt_o     (cnt[j]),
          .zero_o    (zero[j])
        );
      end
    end
  end

  assign root_cnt  = gen_lvl[LEVELS].cnt[0];
  assign root_zero = gen_lvl[LEVELS].zero[0];

  always_comb begin
    all_zero_o = root_zero;
    lz_count_o = root_zero ? CNT_W'(WIDTH) : {1'b0, root_cnt};
  end
endmodule

// File: rtl/lzc_unit_chk.sv
module lzc_unit_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0]          operand_i,
  input logic [$clog2(WIDTH):0]    lz_count_o,
  input logic                      all_zero_o
);
  logic [WIDTH-1:0] at_lead;
  logic [WIDTH-1:0] above_lead;
  int unsigned      cnt_int;

  always_comb begin
    cnt_int    = 32'(lz_count_o);
    at_lead    = operand_i >> (WIDTH - 1 - cnt_int);
    above_lead = (cnt_int == 0) ? '0 : (operand_i >> (WIDTH - cnt_int));
    if (!$isunknown(operand_i)) begin
      AST_ZERO_FULL: assert ((operand_i != '0) || (cnt_int == WIDTH)); // R3
      AST_FLAG_MATCH: assert (all_zero_o == (operand_i == '0)); // R4
      AST_NO_OVERFLOW: assert (cnt_int <= WIDTH); // R7
      AST_MSB_ZERO: assert (!operand_i[WIDTH-1] || (cnt_int == 0)); // R6
      AST_LEAD_SET: assert ((operand_i == '0) || at_lead[0]); // R2
      AST_ABOVE_CLEAR: assert ((operand_i == '0) || (above_lead == '0)); // R2
    end
  end
endmodule

bind lzc_unit lzc_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .operand_i  (operand_i),
  .lz_count_o (lz_count_o),
  .all_zero_o (all_zero_o)
);

// File: tb/lzc_unit_test.sv
module lzc_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic [31:0] op32;
  logic [5:0]  cnt32;
  logic        z32;
  logic [63:0] op64;
  logic [6:0]  cnt64;
  logic        z64;

  int checks;
  int errors;

  lzc_unit #(.WIDTH(32)) uut (
    .operand_i (op32), .lz_count_o (cnt32), .all_zero_o (z32));
  lzc_unit #(.WIDTH(64)) uut64 (
    .operand_i (op64), .lz_count_o (cnt64), .all_zero_o (z64));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_lz32(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return 31 - i;
    return 32;
  endfunction

  function automatic int ref_lz64(input logic [63:0] v);
    for (int i = 63; i >= 0; i--) if (v[i]) return 63 - i;
    return 64;
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic apply32(input logic [31:0] v);
    @(negedge clk);
    op32 = v;
    #1;
  endtask

  task automatic apply64(input logic [63:0] v);
    @(negedge clk);
    op64 = v;
    #1;
  endtask

  task automatic check32(input string req, input logic [31:0] v);
    apply32(v);
    chk(req, $sformatf("count of %08h", v), int'(cnt32), ref_lz32(v));
    chk(req, $sformatf("zero flag of %08h", v), int'(z32), (v == 0) ? 1 : 0);
  endtask

  task automatic t_zero;
    check32("R3", 32'h0);
    chk("R3", "zero count", int'(cnt32), 32);
    chk("R4", "zero flag", int'(z32), 1);
  endtask

  task automatic t_single_bits;
    for (int k = 0; k < 32; k++) begin
      apply32(32'h1 << k);
      chk("R5", $sformatf("single bit %0d", k), int'(cnt32), 31 - k);
      chk("R4", $sformatf("flag single bit %0d", k), int'(z32), 0);
    end
  endtask

  task automatic t_msb;
    check32("R6", 32'hFFFF_FFFF);
    chk("R6", "all ones", int'(cnt32), 0);
    apply32(32'h8000_0000);
    chk("R6", "msb only", int'(cnt32), 0);
  endtask

  task automatic t_leaf_patterns;
    logic [3:0] nib [4] = '{4'b1011, 4'b0110, 4'b0011, 4'b0001};
    for (int p = 0; p < 4; p++) begin
      apply32({nib[p], 28'h5A3C_E71});
      chk("R1", $sformatf("top slice %04b", nib[p]), int'(cnt32), p);
    end
  endtask

  task automatic t_low_ignored;
    for (int k = 1; k < 32; k++) begin
      logic [31:0] base = 32'h1 << k;
      logic [31:0] mask = base - 1;
      apply32(base | (mask & $urandom()));
      chk("R8", $sformatf("low bits below %0d", k), int'(cnt32), 31 - k);
      chk("R8", $sformatf("flag low bits below %0d", k), int'(z32), 0);
    end
  endtask

  task automatic t_random;
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] v = $urandom() >> ($urandom() % 33);
      check32("R2", v);
      checks++;
      if (int'(cnt32) > 32) begin
        errors++;
        $display("FAIL R7 range: got %0d expected at most 32", cnt32);
      end
    end
  endtask

  task automatic t_wide;
    apply64(64'h0);
    chk("R9", "wide zero count", int'(cnt64), 64);
    chk("R9", "wide zero flag", int'(z64), 1);
    for (int k = 0; k < 64; k++) begin
      apply64(64'h1 << k);
      chk("R9", $sformatf("wide single bit %0d", k), int'(cnt64), 63 - k);
    end
    for (int n = 0; n < 300; n++) begin
      logic [63:0] v = {$urandom(), $urandom()} >> ($urandom() % 65);
      apply64(v);
      chk("R9", $sformatf("wide count of %016h", v), int'(cnt64), ref_lz64(v));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    op32 = '0;
    op64 = '0;
    repeat (2) @(posedge clk);
    t_zero();
    t_single_bits();
    t_msb();
    t_leaf_patterns();
    t_low_ignored();
    t_random();
    t_wide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule